// File: doc/BRIEF.md
# Periodic Interval Countdown Timer

A single-channel timer that counts down from a software-programmed start value and starts over on its own each time it expires. A peripheral tick qualifier, synchronous to the system clock, sets the rate: one decrement per tick. When the count is zero and a tick arrives, the timer reloads the start value. In that same clock edge it raises a one-cycle trigger pulse and sets a sticky expiry flag. An interrupt request follows the flag when interrupts are enabled.

The reload and the next countdown never wait for software. The period depends only on the tick stream and never on how quickly the flag is serviced. Software reaches the timer through a small word-wide register interface with four registers: the start value, the live count (read-only), control, and status. Writes take effect at the clock edge where bus select and write are both high. Reads are combinational from the address.

Register map (2-bit address): 0 = start value, 1 = live count, 2 = control (bit 0 run enable, bit 1 interrupt enable), 3 = status (bit 0 expiry flag, write 1 to clear).

Top module: `tick_timer`

## Requirements
- R1: While the reset input is low, and for two clock edges after it rises, all registers read as zero and the trigger and interrupt outputs are low.
- R2: While running, the live count drops by one on each edge where the tick input is high and the count is nonzero. Edges without a tick leave it unchanged.
- R3: With ticks on every edge and start value N, the trigger fires once every N+1 edges.
- R4: When a tick arrives while the count is zero, the count reloads the start value, the trigger output (active high) is high for exactly the following cycle, and status bit 0 is set.
- R5: After a reload the count keeps decrementing on the following ticks even while status bit 0 remains set.
- R6: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged.
- R7: If a clear write and an expiry fall on the same edge, the flag ends up set.
- R8: The interrupt output equals status bit 0 AND control bit 1. The trigger pulse fires regardless of control bit 1.
- R9: A write to the start value while running does not alter the live count. The new value is used at the next reload.
- R10: Writing control bit 0 = 1 while stopped loads the live count from the start value at that edge. Writing it while already running does not reload.
- R11: While control bit 0 is 0, the count holds, and no trigger or flag set occurs even with ticks present.
- R12: Writes to the live count address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Peripheral tick qualifier, one decrement per high cycle |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, zero when not selected |
| trig_o | output | 1 | One-cycle expiry pulse |
| irq_o | output | 1 | Interrupt request (flag AND interrupt enable) |

## Verification
The assertions assume a tick input that is a clean, clock-synchronous level sampled at each edge, and at most one register access per cycle. They also assume that a run-enable write is the only event that loads the count outside a reload. The stimulus drives every input at the falling edge and keeps each write to a single cycle, so none of these assumptions is violated. The same-edge clear-and-expiry case is produced on purpose by driving a tick and a clear in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_START = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned STAT_FLAG_BIT = 0;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     count_i,
  input  logic              flag_i,
  output logic [DW-1:0]     start_val_o,
  output logic              run_o,
  output logic              ie_o,
  output logic              load_now_o,
  output logic              clr_o,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] start_q, start_d;
  logic          run_q, run_d, ie_q, ie_d;
  logic          wr_start, wr_ctrl;

  always_comb begin
    wr_start   = sel_i && wr_i && (addr_i == REG_START);
    wr_ctrl    = sel_i && wr_i && (addr_i == REG_CTRL);
    clr_o      = sel_i && wr_i && (addr_i == REG_STAT) && wdata_i[STAT_FLAG_BIT];
    load_now_o = wr_ctrl && wdata_i[CTRL_RUN_BIT] && !run_q;
    start_d    = wr_start ? wdata_i : start_q;
    run_d      = wr_ctrl ? wdata_i[CTRL_RUN_BIT] : run_q;
    ie_d       = wr_ctrl ? wdata_i[CTRL_IE_BIT] : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (wr_start) start_q <= start_d;
      if (wr_ctrl) begin
        run_q <= run_d;
        ie_q  <= ie_d;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (addr_i)
        REG_START: rdata_o = start_q;
        REG_COUNT: rdata_o = count_i;
        REG_CTRL: begin
          rdata_o[CTRL_RUN_BIT] = run_q;
          rdata_o[CTRL_IE_BIT]  = ie_q;
        end
        REG_STAT:  rdata_o[STAT_FLAG_BIT] = flag_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign start_val_o = start_q;
  assign run_o       = run_q;
  assign ie_o        = ie_q;

  assert_noreload_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !load_now_o);
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          load_now_i,
  input  logic [DW-1:0] start_val_i,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en, at_zero;

  always_comb begin
    at_zero  = (cnt_q == '0);
    expire_o = run_i && tick_i && at_zero;
    cnt_en   = load_now_i || (run_i && tick_i);
    if (load_now_i || at_zero) cnt_d = start_val_i;
    else                       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !at_zero && !load_now_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(start_val_i)));
  assert_hold_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_now_i) |=> $stable(cnt_q));
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_now_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic trig_o
);
  logic flag_q, flag_d, trig_q, flag_en;

  always_comb begin
    flag_en = expire_i || clr_i;
    flag_d  = expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= expire_i;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign trig_o = trig_q;

  assert_trig_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> flag_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && clr_i) |=> flag_q);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !expire_i) |=> !flag_q);
  assert_trig_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !expire_i) |=> !trig_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              trig_o,
  output logic              irq_o
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic [DW-1:0]     start_val, count;
  logic              run, ie, load_now, clr, expire, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  tick_timer_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .count_i(count), .flag_i(flag),
    .start_val_o(start_val), .run_o(run), .ie_o(ie),
    .load_now_o(load_now), .clr_o(clr), .rdata_o(bus_rdata_o)
  );

  tick_timer_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_int_n),
    .run_i(run), .tick_i(tick_i), .load_now_i(load_now), .start_val_i(start_val),
    .count_o(count), .expire_o(expire)
  );

  tick_timer_flag u_flag (
    .clk(clk), .rst_n(rst_int_n),
    .expire_i(expire), .clr_i(clr),
    .flag_o(flag), .trig_o(trig_o)
  );

  assign irq_o = flag & ie;

  assert_trig_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    trig_o |-> $past(run));
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        sel, wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        trig, irq;

  int n_run = 0, n_fail = 0;
  int trig_seen = 0;
  logic [31:0] v;

  // behavioural reference state
  logic [31:0] m_start, m_cnt;
  logic        m_run, m_ie, m_flag, m_trig;
  int          m_rel;
  logic        m_live;

  always #2.5 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .trig_o(trig), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: advances on each rising edge from the sampled inputs
  always @(posedge clk) begin
    logic        expire, bw;
    logic [31:0] nc;
    if (!rst_n) m_rel = 0;
    else if (m_rel < 2) m_rel = m_rel + 1;
    m_live = rst_n && (m_rel >= 2);
    if (!rst_n || m_rel < 2 || !m_live && m_rel < 2) begin
      m_start = 0; m_cnt = 0; m_run = 0; m_ie = 0; m_flag = 0; m_trig = 0;
    end else begin
      bw     = sel && wr;
      expire = m_run && tick && (m_cnt == 0);
      nc     = m_cnt;
      if (bw && addr == 2 && wdata[0] && !m_run) nc = m_start;
      else if (m_run && tick) nc = (m_cnt == 0) ? m_start : m_cnt - 1;
      if (expire) m_flag = 1'b1;
      else if (bw && addr == 3 && wdata[0]) m_flag = 1'b0;
      m_trig = expire;
      m_cnt  = nc;
      if (bw && addr == 0) m_start = wdata;
      if (bw && addr == 2) begin m_run = wdata[0]; m_ie = wdata[1]; end
    end
  end

  // compare with the reference every cycle, well clear of both edges
  always @(negedge clk) begin
    logic [31:0] m_rd;
    #2;
    if (rst_n === 1'b1 && m_rel >= 2) begin
      m_rd = 0;
      if (sel) case (addr)
        2'd0: m_rd = m_start;
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = {30'd0, m_ie, m_run};
        default: m_rd = {31'd0, m_flag};
      endcase
      check("R4 trigger vs model", {31'd0, trig}, {31'd0, m_trig});
      check("R8 irq vs model", {31'd0, irq}, {31'd0, m_flag & m_ie});
      check("R2 read data vs model", rdata, m_rd);
    end
  end

  always @(negedge clk) if (trig === 1'b1) trig_seen++;

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    sel = 1; wr = 0; addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], v); check("R1 reset register", v, 0);
    end
    check("R1 reset trig", {31'd0, trig}, 0);
    check("R1 reset irq", {31'd0, irq}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    bus_read(2'd1, v); check("R1 count after release", v, 0);

    // R10: start from stopped loads immediately
    bus_write(0, 5);
    bus_write(2, 1);
    bus_read(1, v); check("R10 load on enable", v, 5);
    ticks(2);
    bus_read(1, v); check("R2 two ticks", v, 3);
    bus_write(2, 1);
    bus_read(1, v); check("R10 no reload when running", v, 3);
    repeat (3) @(negedge clk);
    bus_read(1, v); check("R2 no tick holds", v, 3);
    ticks(3);
    bus_read(1, v); check("R2 reaches zero", v, 0);
    bus_read(3, v); check("R4 flag not yet set", v, 0);
    ticks(1);
    check("R4 trigger pulse", {31'd0, trig}, 1);
    bus_read(1, v); check("R4 reload value", v, 5);
    bus_read(3, v); check("R4 flag set", v, 1);
    check("R8 irq masked, trigger still fired", {31'd0, irq}, 0);
    ticks(1);
    bus_read(1, v); check("R5 counts with flag set", v, 4);
    check("R4 trigger one cycle", {31'd0, trig}, 0);

    bus_write(2, 3);
    check("R8 irq with enable", {31'd0, irq}, 1);
    bus_write(3, 0);
    bus_read(3, v); check("R6 write 0 keeps flag", v, 1);
    bus_write(3, 1);
    bus_read(3, v); check("R6 write 1 clears flag", v, 0);
    check("R8 irq drops", {31'd0, irq}, 0);

    // R7: clear and expiry on the same edge
    ticks(4);
    @(negedge clk); tick = 1; sel = 1; wr = 1; addr = 3; wdata = 1;
    @(negedge clk); tick = 0; sel = 0; wr = 0; wdata = 0;
    bus_read(3, v); check("R7 set wins over clear", v, 1);
    bus_read(1, v); check("R7 reload on collision", v, 5);

    // R12: count register is read-only
    bus_write(1, 32'd123);
    bus_read(1, v); check("R12 count write ignored", v, 5);

    // R9: new start value waits for reload
    bus_write(0, 2);
    bus_read(1, v); check("R9 count unchanged by start write", v, 5);
    ticks(6);
    bus_read(1, v); check("R9 new start value at reload", v, 2);

    // R11: stopped timer ignores ticks
    bus_write(3, 1);
    bus_write(2, 2);
    trig_seen = 0;
    ticks(10);
    #1;
    bus_read(1, v); check("R11 count held when stopped", v, 2);
    check("R11 no trigger when stopped", trig_seen, 0);
    bus_read(3, v); check("R11 no flag when stopped", v, 0);

    // R3: period is start value plus one
    bus_write(0, 3);
    bus_write(2, 1);
    bus_read(1, v); check("R10 restart loads", v, 3);
    trig_seen = 0;
    ticks(20);
    #1;
    check("R3 pulses in 20 ticks with start 3", trig_seen, 5);
    check("R3 last pulse on 20th tick", {31'd0, trig}, 1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule